// File: doc/BRIEF.md
# Line Prefetch Buffer with In-Flight Stall

This block sits between a host read port and a flash fetch engine. It serves reads that fall in a memory-mapped flash window from a single line buffer. The buffer holds one aligned line of eight 32-bit words. When the host reads a word that is already in the buffer, the data comes back in the same cycle. Such words can be read in any order.

When the host reads a word of a different line, the block asks the fetch engine for the line that contains that address. The engine then returns the words one at a time, in ascending order. A read of a word in the line being filled that has not arrived yet is held. This covers both the word in flight and any later word. The read completes in the cycle after that word is written, so sequential reads can run alongside the fill.

A miss that occurs during a fill waits until the current line is complete before the next line is requested. Only one host read is outstanding at a time, and the host keeps its address stable while it is held.

Top module: `line_prefetch_buf`

## Requirements
- R1: While `rst` is high, and after it falls with no host read pending, `fetch_req_valid` and `host_rd_ready` are low.
- R2: A read of a line that is neither buffered nor being filled raises `fetch_req_valid` with `fetch_req_addr` equal to the byte address of the line base, with bits [4:0] zero. The request holds its address until `fetch_req_ready` is sampled high, and there is exactly one request per new line.
- R3: After a request is accepted, the n-th `fill_valid` word (counting from 0) is stored as word n of the line. Word n is the one addressed by bits [4:2] of the byte address.
- R4: A read of a buffered word gets `host_rd_ready` high in the same cycle, with the stored data and no fetch request. This holds in any order, and address bits [1:0] are ignored.
- R5: A read of the word currently in flight is held with `host_rd_ready` low and the fill continues. `host_rd_ready` rises in the first cycle after that word's `fill_valid`.
- R6: A read of a later, not yet arrived word of the line being filled is held in the same way. It completes in the first cycle after that word arrives, and no new request is made.
- R7: A miss to another line while a fill is in progress issues no request until the last word of the current line has arrived. The request for the new line follows afterwards.
- R8: Once a new line request is accepted, words of the previously buffered line are no longer served. A read of them causes a new request.
- R9: `host_rd_ready` is never high while `host_rd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_rd_valid | input | 1 | Host read pending |
| host_rd_addr | input | ADDR_W | Host byte address, held while pending |
| host_rd_ready | output | 1 | Read completes this cycle |
| host_rd_data | output | DATA_W | Read data, valid with `host_rd_ready` |
| fetch_req_valid | output | 1 | Line fetch request |
| fetch_req_ready | input | 1 | Fetch engine accepts the request |
| fetch_req_addr | output | ADDR_W | Line base byte address |
| fill_valid | input | 1 | A fetched word is delivered |
| fill_data | input | DATA_W | Fetched word |

## Verification
The bench runs a sweep over many lines. Each line starts its reads at a different word, and the remaining words are read in rotating order. Every read's completion cycle is checked against the bench's own count of arrived words. A design that waited for the whole line, or that treated an in-flight hit as a miss, would complete late or issue extra requests. A design that let a read through before its word landed would complete early with stale data.

A miss issued in the middle of a fill targets a request that starts too soon, which would corrupt the fill order. A reread of the displaced line targets a buffer that keeps serving old words after a line switch. Reverse-order reads of a full line, with nonzero byte offsets, target designs that only hit sequentially or that decode the low address bits.

// File: rtl/lpb_pkg.sv
package lpb_pkg;

    localparam int DEF_ADDR_W     = 20;
    localparam int DEF_DATA_W     = 32;
    localparam int DEF_LINE_WORDS = 8;

    typedef enum logic [1:0] {
        FS_IDLE,
        FS_ASK,
        FS_FILL
    } fetch_state_e;

    function automatic int bits_for(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/lpb_addr_split.sv
module lpb_addr_split
    import lpb_pkg::*;
#(
    parameter int ADDR_W     = DEF_ADDR_W,
    parameter int DATA_W     = DEF_DATA_W,
    parameter int LINE_WORDS = DEF_LINE_WORDS,
    localparam int OFF_W     = bits_for(DATA_W / 8),
    localparam int IDX_W     = bits_for(LINE_WORDS),
    localparam int TAG_W     = ADDR_W - IDX_W - OFF_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [TAG_W-1:0]  tag,
    output logic [IDX_W-1:0]  idx
);

    logic unused_byte_sel;

    assign tag             = addr[ADDR_W-1 -: TAG_W];
    assign idx             = addr[OFF_W +: IDX_W];
    assign unused_byte_sel = ^addr[OFF_W-1:0];

endmodule

// File: rtl/lpb_line_state.sv
module lpb_line_state
    import lpb_pkg::*;
#(
    parameter int TAG_W      = 15,
    parameter int LINE_WORDS = DEF_LINE_WORDS,
    localparam int IDX_W     = bits_for(LINE_WORDS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [TAG_W-1:0] load_tag,
    input  logic             fill_we,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [TAG_W-1:0] look_tag,
    input  logic [IDX_W-1:0] look_idx,
    output logic             same_line,
    output logic             word_ok
);

    logic [TAG_W-1:0]      tag_q;
    logic                  live_q;
    logic [LINE_WORDS-1:0] have_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_q  <= '0;
            live_q <= 1'b0;
            have_q <= '0;
        end else if (load) begin
            tag_q  <= load_tag;
            live_q <= 1'b1;
            have_q <= '0;
        end else if (fill_we) begin
            have_q[fill_idx] <= 1'b1;
        end
    end

    assign same_line = live_q && (tag_q == look_tag);
    assign word_ok   = same_line && have_q[look_idx];

endmodule

// File: rtl/lpb_fetch_ctl.sv
module lpb_fetch_ctl
    import lpb_pkg::*;
#(
    parameter int TAG_W      = 15,
    parameter int LINE_WORDS = DEF_LINE_WORDS,
    localparam int IDX_W     = bits_for(LINE_WORDS),
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LINE_WORDS - 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             host_valid,
    input  logic             same_line,
    input  logic [TAG_W-1:0] host_tag,
    input  logic             req_ready,
    input  logic             word_in,
    output logic             req_valid,
    output logic [TAG_W-1:0] req_tag,
    output logic             load,
    output logic             fill_we,
    output logic [IDX_W-1:0] fill_idx
);

    fetch_state_e     state_q;
    logic [TAG_W-1:0] tag_q;
    logic [IDX_W-1:0] ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FS_IDLE;
            tag_q   <= '0;
            ptr_q   <= '0;
        end else begin
            unique case (state_q)
                FS_IDLE: begin
                    if (host_valid && !same_line) begin
                        state_q <= FS_ASK;
                        tag_q   <= host_tag;
                    end
                end
                FS_ASK: begin
                    if (req_ready) begin
                        state_q <= FS_FILL;
                        ptr_q   <= '0;
                    end
                end
                FS_FILL: begin
                    if (word_in) begin
                        ptr_q <= ptr_q + 1'b1;
                        if (ptr_q == LAST_IDX) begin
                            state_q <= FS_IDLE;
                        end
                    end
                end
                default: state_q <= FS_IDLE;
            endcase
        end
    end

    assign req_valid = (state_q == FS_ASK);
    assign req_tag   = tag_q;
    assign load      = req_valid && req_ready;
    assign fill_we   = (state_q == FS_FILL) && word_in;
    assign fill_idx  = ptr_q;

endmodule

// File: rtl/lpb_word_store.sv
module lpb_word_store
    import lpb_pkg::*;
#(
    parameter int DATA_W     = DEF_DATA_W,
    parameter int LINE_WORDS = DEF_LINE_WORDS,
    localparam int IDX_W     = bits_for(LINE_WORDS)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] word_q [LINE_WORDS];

    for (genvar g = 0; g < LINE_WORDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (we && (widx == IDX_W'(g))) begin
                word_q[g] <= wdata;
            end
        end
    end

    assign rdata = word_q[ridx];

endmodule

// File: rtl/line_prefetch_buf.sv
module line_prefetch_buf
    import lpb_pkg::*;
#(
    parameter int ADDR_W     = DEF_ADDR_W,
    parameter int DATA_W     = DEF_DATA_W,
    parameter int LINE_WORDS = DEF_LINE_WORDS,
    localparam int OFF_W     = bits_for(DATA_W / 8),
    localparam int IDX_W     = bits_for(LINE_WORDS),
    localparam int TAG_W     = ADDR_W - IDX_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_rd_valid,
    input  logic [ADDR_W-1:0] host_rd_addr,
    output logic              host_rd_ready,
    output logic [DATA_W-1:0] host_rd_data,
    output logic              fetch_req_valid,
    input  logic              fetch_req_ready,
    output logic [ADDR_W-1:0] fetch_req_addr,
    input  logic              fill_valid,
    input  logic [DATA_W-1:0] fill_data
);

    logic [TAG_W-1:0] host_tag;
    logic [IDX_W-1:0] host_idx;
    logic [TAG_W-1:0] req_tag;
    logic             same_line;
    logic             word_ok;
    logic             load;
    logic             fill_we;
    logic [IDX_W-1:0] fill_idx;

    lpb_addr_split #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_WORDS(LINE_WORDS)
    ) u_split (
        .addr(host_rd_addr), .tag(host_tag), .idx(host_idx)
    );

    lpb_line_state #(
        .TAG_W(TAG_W), .LINE_WORDS(LINE_WORDS)
    ) u_state (
        .clk(clk), .rst(rst),
        .load(load), .load_tag(req_tag),
        .fill_we(fill_we), .fill_idx(fill_idx),
        .look_tag(host_tag), .look_idx(host_idx),
        .same_line(same_line), .word_ok(word_ok)
    );

    lpb_fetch_ctl #(
        .TAG_W(TAG_W), .LINE_WORDS(LINE_WORDS)
    ) u_ctl (
        .clk(clk), .rst(rst),
        .host_valid(host_rd_valid), .same_line(same_line),
        .host_tag(host_tag),
        .req_ready(fetch_req_ready), .word_in(fill_valid),
        .req_valid(fetch_req_valid), .req_tag(req_tag),
        .load(load), .fill_we(fill_we), .fill_idx(fill_idx)
    );

    lpb_word_store #(
        .DATA_W(DATA_W), .LINE_WORDS(LINE_WORDS)
    ) u_store (
        .clk(clk), .we(fill_we), .widx(fill_idx), .wdata(fill_data),
        .ridx(host_idx), .rdata(host_rd_data)
    );

    assign host_rd_ready  = host_rd_valid && word_ok;
    assign fetch_req_addr = {req_tag, {(IDX_W + OFF_W){1'b0}}};

endmodule

// File: rtl/lpb_checker.sv
module lpb_checker
    import lpb_pkg::*;
#(
    parameter int ADDR_W     = DEF_ADDR_W,
    parameter int DATA_W     = DEF_DATA_W,
    parameter int LINE_WORDS = DEF_LINE_WORDS,
    localparam int LOW_W     = bits_for(DATA_W / 8) + bits_for(LINE_WORDS),
    localparam int CNT_W     = bits_for(LINE_WORDS) + 1
) (
    input logic              clk,
    input logic              rst,
    input logic              host_rd_valid,
    input logic              host_rd_ready,
    input logic              fetch_req_valid,
    input logic              fetch_req_ready,
    input logic [ADDR_W-1:0] fetch_req_addr,
    input logic              fill_valid
);

    logic [CNT_W-1:0] owed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            owed_q <= '0;
        end else if (fetch_req_valid && fetch_req_ready) begin
            owed_q <= CNT_W'(LINE_WORDS);
        end else if (fill_valid && owed_q != '0) begin
            owed_q <= owed_q - 1'b1;
        end
    end

    AST_QUIET_IN_RESET: assert property (@(posedge clk)
        rst |=> !fetch_req_valid && !host_rd_ready); // R1

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        fetch_req_valid && !fetch_req_ready |=> fetch_req_valid && $stable(fetch_req_addr)); // R2

    AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        fetch_req_valid |-> fetch_req_addr[LOW_W-1:0] == '0); // R2

    AST_HIT_NO_FETCH: assert property (@(posedge clk) disable iff (rst)
        host_rd_ready |-> !fetch_req_valid); // R4

    AST_NO_REQ_IN_FILL: assert property (@(posedge clk) disable iff (rst)
        fetch_req_valid |-> owed_q == '0); // R7

    AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        host_rd_ready |-> host_rd_valid); // R9

endmodule

bind line_prefetch_buf lpb_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_WORDS(LINE_WORDS)
) u_chk (
    .clk(clk), .rst(rst),
    .host_rd_valid(host_rd_valid), .host_rd_ready(host_rd_ready),
    .fetch_req_valid(fetch_req_valid), .fetch_req_ready(fetch_req_ready),
    .fetch_req_addr(fetch_req_addr), .fill_valid(fill_valid)
);

// File: tb/tb_line_prefetch_buf.sv
module tb_line_prefetch_buf;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 20;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          host_rd_valid = 1'b0;
    logic [AW-1:0] host_rd_addr = '0;
    logic          host_rd_ready;
    logic [DW-1:0] host_rd_data;
    logic          fetch_req_valid;
    logic          fetch_req_ready = 1'b0;
    logic [AW-1:0] fetch_req_addr;
    logic          fill_valid = 1'b0;
    logic [DW-1:0] fill_data = '0;

    int checks = 0;
    int errors = 0;
    int req_cnt = 0;
    int fills_done = 0;
    int early_req = 0;
    bit line_known = 1'b0;
    logic [AW-6:0] cur_line = '0;
    logic [AW-1:0] last_req_addr = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    line_prefetch_buf dut (
        .clk(clk), .rst(rst),
        .host_rd_valid(host_rd_valid), .host_rd_addr(host_rd_addr),
        .host_rd_ready(host_rd_ready), .host_rd_data(host_rd_data),
        .fetch_req_valid(fetch_req_valid), .fetch_req_ready(fetch_req_ready),
        .fetch_req_addr(fetch_req_addr),
        .fill_valid(fill_valid), .fill_data(fill_data)
    );

    function automatic logic [31:0] flash_word(input logic [AW-1:0] byte_addr);
        logic [31:0] wa;
        wa = 32'(byte_addr >> 2);
        return (wa * 32'h9E3779B1) ^ 32'hC0DE0000;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // bench view of fetch progress
    always @(posedge clk) begin
        if (!rst) begin
            if (fetch_req_valid && line_known && fills_done < 8) early_req++;
            if (fetch_req_valid && fetch_req_ready) begin
                req_cnt++;
                last_req_addr = fetch_req_addr;
                cur_line = fetch_req_addr[AW-1:5];
                line_known = 1'b1;
                fills_done = 0;
            end else if (fill_valid) begin
                fills_done++;
            end
        end
    end

    // flash engine model: accepts after a delay, returns words with gaps
    initial begin
        forever begin
            logic [AW-1:0] base;
            @(negedge clk);
            if (!rst && fetch_req_valid) begin
                repeat (2) @(negedge clk);
                fetch_req_ready = 1'b1;
                base = fetch_req_addr;
                @(negedge clk);
                fetch_req_ready = 1'b0;
                for (int w = 0; w < 8; w++) begin
                    repeat (w % 3) @(negedge clk);
                    fill_valid = 1'b1;
                    fill_data  = flash_word(base + AW'(4 * w));
                    @(negedge clk);
                    fill_valid = 1'b0;
                    fill_data  = '0;
                end
            end
        end
    end

    function automatic bit landed(input logic [AW-1:0] a);
        return line_known && (cur_line == a[AW-1:5]) && (fills_done > int'(a[4:2]));
    endfunction

    // called at a negedge; returns at a negedge with the read done
    task automatic do_read(input logic [AW-1:0] a, input bit expect_hit);
        int    waited;
        int    rc;
        bit    late;
        string tag;
        waited = 0;
        late = 1'b0;
        rc = req_cnt;
        if (line_known && cur_line == a[AW-1:5] && fills_done == int'(a[4:2])) tag = "R5";
        else if (line_known && cur_line == a[AW-1:5] && fills_done < int'(a[4:2])) tag = "R6";
        else tag = "R2";
        host_rd_addr  = a;
        host_rd_valid = 1'b1;
        #1;
        while (!host_rd_ready && waited < 500) begin
            if (landed(a)) late = 1'b1;
            @(negedge clk);
            #1;
            waited++;
        end
        chk(host_rd_ready && landed(a) && !late, tag, "stall release timing",
            32'(waited), 32'(a));
        chk(host_rd_data == flash_word(a), "R3", "read data", host_rd_data, flash_word(a));
        if (expect_hit) begin
            chk(waited == 0 && req_cnt == rc, "R4", "hit served at once",
                32'(waited), 32'(0));
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [AW-1:0] base;
        int rc;
        // R1 reset state
        repeat (3) @(negedge clk);
        chk(!fetch_req_valid && !host_rd_ready, "R1", "quiet in reset",
            {30'b0, fetch_req_valid, host_rd_ready}, 32'd0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(!fetch_req_valid && req_cnt == 0, "R1", "no request when idle",
            32'(req_cnt), 32'd0);

        // miss to a fresh line, then sequential reads overlapping the fill
        base = 20'h00100;
        do_read(base + 20'd12, 1'b0);
        chk(last_req_addr == base && req_cnt == 1, "R2", "line base request",
            32'(last_req_addr), 32'(base));
        for (int w = 0; w < 8; w++) do_read(base + AW'(4 * w), 1'b0);
        chk(req_cnt == 1, "R6", "no refetch inside line", 32'(req_cnt), 32'd1);

        // reverse order hits with byte offsets
        for (int w = 7; w >= 0; w--) do_read(base + AW'(4 * w) + AW'(w % 4), 1'b1);

        // R9 idle
        host_rd_valid = 1'b0;
        @(negedge clk);
        #1;
        chk(!host_rd_ready, "R9", "ready without valid", 32'(host_rd_ready), 32'd0);
        @(negedge clk);

        // R7 miss during fill, R8 displaced line
        do_read(20'h00200, 1'b0);
        early_req = 0;
        do_read(20'h00314, 1'b0);
        chk(early_req == 0, "R7", "no request during fill", 32'(early_req), 32'd0);
        chk(last_req_addr == 20'h00300 && req_cnt == 3, "R7", "next line requested",
            32'(last_req_addr), 32'h300);
        rc = req_cnt;
        do_read(20'h00200, 1'b0);
        chk(req_cnt == rc + 1, "R8", "old line refetched", 32'(req_cnt), 32'(rc + 1));

        // sweep: rotating start word per line
        for (int l = 0; l < 16; l++) begin
            logic [AW-1:0] lb;
            lb = 20'h04000 + AW'(32 * l);
            rc = req_cnt;
            for (int k = 0; k < 8; k++) do_read(lb + AW'(4 * ((l + k) % 8)), 1'b0);
            chk(req_cnt == rc + 1, "R2", "one request per line", 32'(req_cnt), 32'(rc + 1));
        end
        chk(early_req == 0, "R7", "no overlapping requests in sweep", 32'(early_req), 32'd0);

        host_rd_valid = 1'b0;
        repeat (30) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule